// File: doc/BRIEF.md
# Flash Busy-Status Read Multiplexer

This block decides what a read of the flash array returns while the embedded program/erase engine is running, has finished an erase, or holds an erase in suspension. In those states a half-word read in programming mode gets an 8-bit status byte in its low half instead of memory contents. The byte reports a data-polling bit, two toggle bits, a time-limit bit and an erase-window bit. At all other times, and for reads from sectors that a suspended erase does not touch, the array data passes through unchanged.

The engine state, bit 7 of the half-word being programmed, the time-limit flag, the erase-window flag and the mask of sectors queued for erase all come from the sequencer. The read path supplies the sector index of the read address, the width of the access and a read strobe. Two toggle registers advance on strobed reads that return status. Both are cleared when a new command is accepted, so the host can tell that an operation is still running by comparing successive reads.

Top module: `flash_status_mux`

## Requirements
- R1: When `mode_prog` is 0 (32-bit read-only mode) or `rd_word` is 1, `rd_data` equals `array_rdata`, whatever the engine state is.
- R2: With `seq_state` 0 (idle) or any code from 6 to 7, `rd_data` equals `array_rdata`.
- R3: With `seq_state` 1 (program busy), the status byte has bit 7 = inverse of `pd_bit7`, bit 6 = toggle A, bit 5 = `tlim_hit`, bit 3 = 0 and bit 2 = 0.
- R4: With `seq_state` 2 (sector erase busy), the status byte has bit 7 = 0, bit 6 = toggle A, bit 5 = `tlim_hit`, bit 3 = inverse of `ewin_open` and bit 2 = toggle B.
- R5: With `seq_state` 3 (chip erase busy), the status byte has bit 7 = 0, bit 6 = toggle A, bit 5 = `tlim_hit`, bit 3 = 1 and bit 2 = toggle B.
- R6: A strobed status read flips toggle A in states 1 to 3. It flips toggle B in states 2 and 3, and in state 4 when the read hits a marked sector. Cycles without such a read hold both toggles.
- R7: With `seq_state` 4 (erase suspended) and `erase_mask[rd_sector]` set, the status byte is bits 7..3 = 00001 and bit 2 = toggle B.
- R8: With `seq_state` 4 and `erase_mask[rd_sector]` clear, `rd_data` equals `array_rdata`, and neither toggle advances.
- R9: With `seq_state` 5 (erase finished), `rd_data` is `array_rdata` with bit 7 forced to 1.
- R10: Whenever a status byte of states 1 to 4 is returned, `rd_data[15:8]`, bit 4, bit 1 and bit 0 are 0.
- R11: Reset and `cmd_start` clear both toggles. A read in the same cycle as `cmd_start` still returns the old toggle values, and the next status read shows 0 in both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_prog | input | 1 | 1 = 16-bit programming mode, 0 = 32-bit read-only mode |
| rd_word | input | 1 | Current read is word width |
| rd_stb | input | 1 | Read strobe; advances toggles on status reads |
| cmd_start | input | 1 | A new command was accepted; clears toggles |
| seq_state | input | 3 | Engine state code (0 idle, 1 program, 2 sector erase, 3 chip erase, 4 suspended, 5 erase finished) |
| pd_bit7 | input | 1 | Bit 7 of the half-word being programmed |
| tlim_hit | input | 1 | Internal time limit exceeded |
| ewin_open | input | 1 | Sector-erase acceptance window still open |
| erase_mask | input | NSECT | Sectors queued for erase |
| rd_sector | input | SECW | Sector index of the read address |
| array_rdata | input | 16 | Data read from the array |
| rd_data | output | 16 | Returned read data |
| status_sel | output | 1 | Status, not plain array data, is being returned |

## Verification
A status read and a new command can fall in the same cycle. The outcome then decides whether the strobed read reports the old toggle phase and whether the clear wins over the flip. The bench drives `cmd_start` together with `rd_stb` in directed cases and also lets both land together under random stimulus. It judges the current read against the toggle values it holds before the clear, and the following status read against zero. A second collision is a strobe in a suspended state that alternates between marked and unmarked sectors, where only the marked reads may advance toggle B.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

  localparam logic [2:0] SQ_IDLE   = 3'd0;
  localparam logic [2:0] SQ_PROG   = 3'd1;
  localparam logic [2:0] SQ_SERASE = 3'd2;
  localparam logic [2:0] SQ_CERASE = 3'd3;
  localparam logic [2:0] SQ_SUSP   = 3'd4;
  localparam logic [2:0] SQ_EFIN   = 3'd5;

  localparam int B_POLL = 7;
  localparam int B_TOGA = 6;
  localparam int B_TLIM = 5;
  localparam int B_EWIN = 3;
  localparam int B_TOGB = 2;

  // Status byte for the busy states and for a marked sector in suspension.
  function automatic logic [7:0] busy_byte(input logic [2:0] st,
                                           input logic pd7,
                                           input logic tlim,
                                           input logic ewin,
                                           input logic ta,
                                           input logic tb);
    logic [7:0] b;
    b = 8'h00;
    case (st)
      SQ_PROG: begin
        b[B_POLL] = ~pd7;
        b[B_TOGA] = ta;
        b[B_TLIM] = tlim;
      end
      SQ_SERASE: begin
        b[B_TOGA] = ta;
        b[B_TLIM] = tlim;
        b[B_EWIN] = ~ewin;
        b[B_TOGB] = tb;
      end
      SQ_CERASE: begin
        b[B_TOGA] = ta;
        b[B_TLIM] = tlim;
        b[B_EWIN] = 1'b1;
        b[B_TOGB] = tb;
      end
      SQ_SUSP: begin
        b[B_EWIN] = 1'b1;
        b[B_TOGB] = tb;
      end
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic is_busy(input logic [2:0] st);
    return (st == SQ_PROG) || (st == SQ_SERASE) || (st == SQ_CERASE);
  endfunction

  function automatic logic is_erasing(input logic [2:0] st);
    return (st == SQ_SERASE) || (st == SQ_CERASE);
  endfunction

endpackage

// File: rtl/flsr_toggle.sv
module flsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/flsr_select.sv
module flsr_select
  import flsr_pkg::*;
#(
  parameter int NSECT = 4,
  localparam int SECW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             mode_prog,
  input  logic             rd_word,
  input  logic             rd_stb,
  input  logic [2:0]       seq_state,
  input  logic [NSECT-1:0] erase_mask,
  input  logic [SECW-1:0]  rd_sector,
  output logic             marked,
  output logic             status_sel,
  output logic             efin_sel,
  output logic             adv_a,
  output logic             adv_b
);
  logic half_read;
  logic susp_hit;

  assign marked    = erase_mask[rd_sector];
  assign half_read = mode_prog && !rd_word;
  assign susp_hit  = (seq_state == SQ_SUSP) && marked;

  always_comb begin
    status_sel = half_read &&
                 (is_busy(seq_state) || susp_hit || (seq_state == SQ_EFIN));
    efin_sel   = half_read && (seq_state == SQ_EFIN);
    adv_a      = rd_stb && half_read && is_busy(seq_state);
    adv_b      = rd_stb && half_read && (is_erasing(seq_state) || susp_hit);
  end
endmodule

// File: rtl/flsr_compose.sv
module flsr_compose
  import flsr_pkg::*;
(
  input  logic [2:0]  seq_state,
  input  logic        status_sel,
  input  logic        efin_sel,
  input  logic        pd_bit7,
  input  logic        tlim_hit,
  input  logic        ewin_open,
  input  logic        tog_a,
  input  logic        tog_b,
  input  logic [15:0] array_rdata,
  output logic [15:0] rd_data
);
  logic [7:0] sbyte;

  assign sbyte = busy_byte(seq_state, pd_bit7, tlim_hit, ewin_open, tog_a, tog_b);

  always_comb begin
    if (!status_sel)   rd_data = array_rdata;
    else if (efin_sel) rd_data = {array_rdata[15:8], 1'b1, array_rdata[6:0]};
    else               rd_data = {8'h00, sbyte};
  end
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flsr_pkg::*;
#(
  parameter int NSECT = 4,
  localparam int SECW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_prog,
  input  logic             rd_word,
  input  logic             rd_stb,
  input  logic             cmd_start,
  input  logic [2:0]       seq_state,
  input  logic             pd_bit7,
  input  logic             tlim_hit,
  input  logic             ewin_open,
  input  logic [NSECT-1:0] erase_mask,
  input  logic [SECW-1:0]  rd_sector,
  input  logic [15:0]      array_rdata,
  output logic [15:0]      rd_data,
  output logic             status_sel
);
  logic marked;
  logic efin_sel;
  logic adv_a, adv_b;
  logic tog_a_q, tog_b_q;
  logic [1:0] adv_v, tog_v;

  flsr_select #(.NSECT(NSECT)) u_sel (
    .mode_prog  (mode_prog),
    .rd_word    (rd_word),
    .rd_stb     (rd_stb),
    .seq_state  (seq_state),
    .erase_mask (erase_mask),
    .rd_sector  (rd_sector),
    .marked     (marked),
    .status_sel (status_sel),
    .efin_sel   (efin_sel),
    .adv_a      (adv_a),
    .adv_b      (adv_b)
  );

  assign adv_v = {adv_b, adv_a};

  for (genvar g = 0; g < 2; g++) begin : g_tog
    flsr_toggle u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_start),
      .adv   (adv_v[g]),
      .q     (tog_v[g])
    );
  end

  assign tog_a_q = tog_v[0];
  assign tog_b_q = tog_v[1];

  flsr_compose u_cmp (
    .seq_state   (seq_state),
    .status_sel  (status_sel),
    .efin_sel    (efin_sel),
    .pd_bit7     (pd_bit7),
    .tlim_hit    (tlim_hit),
    .ewin_open   (ewin_open),
    .tog_a       (tog_a_q),
    .tog_b       (tog_b_q),
    .array_rdata (array_rdata),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/flsr_checker.sv
module flsr_checker #(
  parameter int NSECT = 4,
  localparam int SECW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_prog,
  input logic             rd_word,
  input logic             cmd_start,
  input logic [2:0]       seq_state,
  input logic             pd_bit7,
  input logic [NSECT-1:0] erase_mask,
  input logic [SECW-1:0]  rd_sector,
  input logic [15:0]      array_rdata,
  input logic [15:0]      rd_data,
  input logic             status_sel,
  input logic             adv_a,
  input logic             tog_a,
  input logic             tog_b
);
  p_rom_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_prog || rd_word) |-> (rd_data == array_rdata));

  p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && !rd_word && seq_state == 3'd1) |->
      (rd_data[7] == !pd_bit7 && rd_data[2] == 1'b0 && rd_data[6] == tog_a));

  p_tog_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_a && !cmd_start) |=> (tog_a != $past(tog_a)));

  p_tog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_a && !cmd_start) |=> $stable(tog_a));

  p_susp_pattern_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && !rd_word && seq_state == 3'd4 && erase_mask[rd_sector]) |->
      (rd_data[7:3] == 5'b00001 && rd_data[2] == tog_b));

  p_susp_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && !erase_mask[rd_sector] && !cmd_start) |=> $stable(tog_b));

  p_zero_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel && seq_state != 3'd5) |->
      (rd_data[15:8] == 8'h00 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

  p_cmd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (!tog_a && !tog_b));
endmodule

bind flash_status_mux flsr_checker #(.NSECT(NSECT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_prog   (mode_prog),
  .rd_word     (rd_word),
  .cmd_start   (cmd_start),
  .seq_state   (seq_state),
  .pd_bit7     (pd_bit7),
  .erase_mask  (erase_mask),
  .rd_sector   (rd_sector),
  .array_rdata (array_rdata),
  .rd_data     (rd_data),
  .status_sel  (status_sel),
  .adv_a       (adv_a),
  .tog_a       (tog_a_q),
  .tog_b       (tog_b_q)
);

// File: tb/tb_flash_status_mux.sv
module tb_flash_status_mux;
  localparam int CLK_P = 10;
  localparam int NSECT = 4;
  localparam int SECW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_prog = 1'b0, rd_word = 1'b0, rd_stb = 1'b0, cmd_start = 1'b0;
  logic [2:0] seq_state = 3'd0;
  logic pd_bit7 = 1'b0, tlim_hit = 1'b0, ewin_open = 1'b0;
  logic [NSECT-1:0] erase_mask = '0;
  logic [SECW-1:0] rd_sector = '0;
  logic [15:0] array_rdata = 16'h0000;
  logic [15:0] rd_data;
  logic status_sel;

  int n_run = 0, n_fail = 0;
  logic m_ta = 1'b0, m_tb = 1'b0;

  flash_status_mux #(.NSECT(NSECT)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [15:0] expect_rd();
    logic hit;
    hit = erase_mask[rd_sector];
    if (!mode_prog || rd_word) return array_rdata;
    case (seq_state)
      3'd1: return {8'h00, ~pd_bit7, m_ta, tlim_hit, 5'b00000};
      3'd2: return {8'h00, 1'b0, m_ta, tlim_hit, 1'b0, ~ewin_open, m_tb, 2'b00};
      3'd3: return {8'h00, 1'b0, m_ta, tlim_hit, 1'b0, 1'b1, m_tb, 2'b00};
      3'd4: return hit ? {8'h00, 5'b00001, m_tb, 2'b00} : array_rdata;
      3'd5: return array_rdata | 16'h0080;
      default: return array_rdata;
    endcase
  endfunction

  function automatic string tag_of();
    if (!mode_prog || rd_word) return "R1";
    case (seq_state)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return erase_mask[rd_sector] ? "R7" : "R8";
      3'd5: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (state %0d)", tag, got, exp, seq_state);
    end
  endtask

  // Update the reference toggles for the coming clock edge.
  task automatic model_edge();
    logic half;
    half = mode_prog && !rd_word;
    if (cmd_start) begin
      m_ta = 1'b0; m_tb = 1'b0;
    end else if (rd_stb && half) begin
      if (seq_state inside {3'd1, 3'd2, 3'd3}) m_ta = ~m_ta;
      if (seq_state inside {3'd2, 3'd3} || (seq_state == 3'd4 && erase_mask[rd_sector]))
        m_tb = ~m_tb;
    end
  endtask

  // Inputs are set after a falling edge; check a quarter period later, then advance.
  task automatic cyc();
    #(CLK_P/4);
    check(tag_of(), rd_data, expect_rd());
    model_edge();
    @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] st, input logic stb);
    mode_prog = 1'b1; rd_word = 1'b0; cmd_start = 1'b0;
    seq_state = st; rd_stb = stb;
  endtask

  initial begin
    logic [15:0] r0, r1;
    @(negedge clk);
    array_rdata = 16'hA5C3; seq_state = 3'd2; mode_prog = 1'b0;
    #(CLK_P/4);
    check("R1", rd_data, 16'hA5C3);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state of toggles: first status read shows both zero (R11)
    setup(3'd3, 1'b0); tlim_hit = 1'b0;
    #(CLK_P/4);
    check("R11", rd_data & 16'h0044, 16'h0000);
    @(negedge clk);

    // R6: consecutive strobed sector-erase reads flip bits 6 and 2
    setup(3'd2, 1'b1); ewin_open = 1'b1;
    #(CLK_P/4); r0 = rd_data; @(negedge clk);
    #(CLK_P/4); r1 = rd_data;
    check("R6", r1 & 16'h0044, ~r0 & 16'h0044);
    m_ta = r1[6]; m_tb = r1[2];
    rd_stb = 1'b0; @(negedge clk);
    m_ta = ~m_ta; m_tb = ~m_tb;
    #(CLK_P/4); r0 = rd_data; @(negedge clk);
    #(CLK_P/4);
    check("R6", rd_data, r0);
    @(negedge clk);

    // R8: unmarked reads during suspension do not move toggle B
    erase_mask = 4'b0010; setup(3'd4, 1'b1); rd_sector = 2'd1;
    array_rdata = 16'hFFFF;
    #(CLK_P/4); r0 = rd_data; @(negedge clk);
    rd_sector = 2'd3;
    #(CLK_P/4); check("R8", rd_data, 16'hFFFF); @(negedge clk);
    #(CLK_P/4); check("R8", rd_data, 16'hFFFF); @(negedge clk);
    rd_sector = 2'd1; rd_stb = 1'b0;
    #(CLK_P/4); check("R8", rd_data, r0 ^ 16'h0004);
    check("R7", rd_data & 16'hFFF8, 16'h0008);
    m_tb = rd_data[2];
    @(negedge clk);

    // R10: all-ones array and inputs still leave unused positions zero
    setup(3'd1, 1'b0); pd_bit7 = 1'b0; tlim_hit = 1'b1;
    #(CLK_P/4); check("R10", rd_data & 16'hFF1F, 16'h0000);
    check("R3", rd_data & 16'h00A0, 16'h00A0);
    @(negedge clk);

    // R11: command start together with a strobed read
    setup(3'd3, 1'b1);
    #(CLK_P/4); r0 = rd_data; @(negedge clk);
    rd_stb = 1'b1; cmd_start = 1'b1;
    #(CLK_P/4); check("R11", rd_data & 16'h0044, ~r0 & 16'h0044); @(negedge clk);
    rd_stb = 1'b0; cmd_start = 1'b0;
    #(CLK_P/4); check("R11", rd_data & 16'h0044, 16'h0000); @(negedge clk);
    m_ta = 1'b0; m_tb = 1'b0;

    // R9 and R1/R2 directed
    setup(3'd5, 1'b1); array_rdata = 16'h1234;
    #(CLK_P/4); check("R9", rd_data, 16'h12B4); @(negedge clk);
    setup(3'd2, 1'b1); rd_word = 1'b1;
    #(CLK_P/4); check("R1", rd_data, 16'h1234); @(negedge clk);
    setup(3'd7, 1'b1);
    #(CLK_P/4); check("R2", rd_data, 16'h1234); @(negedge clk);

    // Constrained random mix with reference model
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      mode_prog   = ($urandom_range(0, 7) != 0);
      rd_word     = ($urandom_range(0, 7) == 0);
      rd_stb      = ($urandom_range(0, 3) != 0);
      cmd_start   = ($urandom_range(0, 15) == 0);
      seq_state   = 3'($urandom_range(0, 7));
      pd_bit7     = 1'($urandom);
      tlim_hit    = ($urandom_range(0, 5) == 0);
      ewin_open   = 1'($urandom);
      erase_mask  = 4'($urandom);
      rd_sector   = 2'($urandom);
      array_rdata = 16'($urandom);
      cyc();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule